// File: doc/BRIEF.md
# Colour LCD Controller Register File

This block is the software-visible register bank of a colour LCD controller. It decodes a 4 KB window on a 32-bit read/write request port. It keeps four timing words, the base addresses of the upper and lower panels, a control word, an interrupt mask and a sticky raw interrupt status. It turns the timing words into an active pixel count per line and an active line count. It drives the enable state, the bits-per-pixel mode and the byte, pixel and colour-order flags as plain pins to the display datapath.

One slice of the window is passed through to an external palette store. Another slice returns fixed identification bytes. A static variant input picks the register map. Variant 0 is the base layout. Any non-zero variant swaps the locations of the mask and control words. Variants 2 and 3 also report the extended identification bytes. The datapath raises status events through a per-bit set input. The interrupt output follows the masked status.

Requests use valid/ready. A request is accepted on a rising edge where both are high. The request fields must stay stable while valid is high and ready is low. Ready is low only for a palette-window request while the palette store holds its ready low. Every accepted read gives one response beat with no back-pressure.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset, every register reads as zero, `irq` and `disp_on` are low, `line_pixels` is 16 and `line_count` is 1.
- R2: Words 0 to 3 (byte offsets 0x00 to 0x0C) hold the four 32-bit timing words and word 4 / word 5 hold the upper / lower panel base. All six read back what was written. Words 11 and 12 are read-only and return the upper and lower base.
- R3: With `cfg_variant` = 0, word 6 is the interrupt mask and word 7 is control. With any non-zero variant, the two are swapped for both reads and writes. The mask keeps only its low IRQ_W bits and reads zero above them.
- R4: `line_pixels` equals ((timing0 & 0xFC) + 4) * 4 and `line_count` equals (timing1 & 0x3FF) + 1. Both change only on the edge that accepts a write.
- R5: The control word decodes as follows: bit 0 enable, bits [3:1] `bpp_mode`, bit 8 `ctl_bgr`, bit 9 `ctl_be_byte`, bit 10 `ctl_be_pixel` and bit 11 power. `disp_on` is high only when both bit 0 and bit 11 are set.
- R6: A high `evt_set` bit sets the matching raw status bit on the next edge. A write to word 10 clears every raw bit written as 1, and a set in the same cycle wins. Word 8 reads the raw status and word 9 reads raw AND mask.
- R7: `irq` is high exactly when raw status AND mask is non-zero, in the same cycle that status or mask changes.
- R8: Byte offsets 0xFE0 to 0xFFC each return one identification byte in bits [7:0]. In ascending order the bytes are 10 11 04 00 0D F0 05 B1 (hex) when `cfg_variant[1]` is 0, and 11 11 24 00 0D F0 05 B1 when it is 1.
- R9: Byte offsets 0x200 to 0x3FF go to the palette port as 128 word entries with `pal_index` = address bits [8:2]. A palette access completes on the edge where `pal_valid` and `pal_ready` are both high, and reads return `pal_rdata` from that edge.
- R10: Reads of undefined offsets return zero. Writes to undefined or read-only offsets (words 8, 9, 11, 12 and the ID range) change nothing.
- R11: `geom_changed` is high for exactly the one cycle after an accepted write to timing0, timing1 or control, wherever control sits for the variant.
- R12: `rsp_valid` is high for exactly the one cycle after each accepted read, with `rsp_data` holding the read value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_variant | input | 2 | Register map variant (0 base, non-zero swaps mask/control, bit 1 selects extended ID) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data |
| pal_valid | output | 1 | Palette access valid |
| pal_ready | input | 1 | Palette store ready |
| pal_write | output | 1 | Palette access is a write |
| pal_index | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data for `pal_index` |
| evt_set | input | IRQ_W | Per-bit status set pulses |
| irq | output | 1 | Interrupt request |
| disp_on | output | 1 | Enable and power both set |
| bpp_mode | output | 3 | Bits-per-pixel mode |
| ctl_bgr | output | 1 | Colour order swap |
| ctl_be_byte | output | 1 | Big-endian byte order |
| ctl_be_pixel | output | 1 | Big-endian pixel order |
| line_pixels | output | 11 | Active pixels per line |
| line_count | output | 11 | Active lines per panel |
| geom_changed | output | 1 | One-cycle pulse after a geometry-affecting write |

## Verification
The bench builds the block with the default IRQ_W of 5. That width is small enough for random mask, clear and event patterns to reach all-set, all-clear and mixed states. It also lets the bench check that the mask drops bits written above that width. The palette ready signal stalls at random, so requests are held under back-pressure. Changing the variant in the middle of a run exercises the mask/control swap and both identification sets against the same stored contents.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int unsigned WORD_W = 10;

  // One-hot register selects produced by the address decoder
  typedef struct packed {
    logic tim0;
    logic tim1;
    logic tim2;
    logic tim3;
    logic ubase;
    logic lbase;
    logic mask;
    logic ctrl;
    logic raw;
    logic mstat;
    logic clr;
    logic ucur;
    logic lcur;
    logic ident;
    logic pal;
  } lcdc_sel_t;

  function automatic logic [7:0] lcdc_id_byte(input logic ext, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = ext ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = ext ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
module lcdc_addr_decode
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              swap,
  output lcdc_sel_t         sel,
  output logic [IDX_W-1:0]  pal_idx,
  output logic [2:0]        id_idx
);
  logic [WORD_W-1:0] word;

  assign word    = addr[ADDR_W-1:2];
  assign pal_idx = addr[IDX_W+1:2];
  assign id_idx  = addr[4:2];

  always_comb begin
    sel = '0;
    if (addr[ADDR_W-1:5] == '1) begin
      sel.ident = 1'b1;
    end else if (addr[ADDR_W-1:9] == 3'b001) begin
      sel.pal = 1'b1;
    end else begin
      case (word)
        10'd0:  sel.tim0  = 1'b1;
        10'd1:  sel.tim1  = 1'b1;
        10'd2:  sel.tim2  = 1'b1;
        10'd3:  sel.tim3  = 1'b1;
        10'd4:  sel.ubase = 1'b1;
        10'd5:  sel.lbase = 1'b1;
        10'd6:  if (swap) sel.ctrl = 1'b1; else sel.mask = 1'b1;
        10'd7:  if (swap) sel.mask = 1'b1; else sel.ctrl = 1'b1;
        10'd8:  sel.raw   = 1'b1;
        10'd9:  sel.mstat = 1'b1;
        10'd10: sel.clr   = 1'b1;
        10'd11: sel.ucur  = 1'b1;
        10'd12: sel.lcur  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_irq_block.sv
module lcdc_irq_block #(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_q, mask_q, raw_kept;

  assign raw_kept = clr_we ? (raw_q & ~clr_bits) : raw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_kept | evt_set;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((raw_o & $past(evt_set)) == $past(evt_set)));

  a_r6_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_set == '0) |=> ((raw_o & $past(clr_bits)) == '0));

  a_r6_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && evt_set == '0) |=> $stable(raw_o));
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int DATA_W = 32,
  parameter int PIX_W  = 11,
  parameter int LINE_W = 11
) (
  input  logic [DATA_W-1:0] tim0,
  input  logic [DATA_W-1:0] tim1,
  output logic [PIX_W-1:0]  line_pixels,
  output logic [LINE_W-1:0] line_count
);
  localparam int PPL_W = PIX_W - 4;
  logic [PPL_W-1:0] groups;

  // ((t0 & 0xFC) + 4) * 4 == (t0[7:2] + 1) * 16
  assign groups      = PPL_W'(tim0[7:2]) + PPL_W'(1);
  assign line_pixels = {groups, 4'b0000};
  assign line_count  = LINE_W'(tim1[9:0]) + LINE_W'(1);
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
  import lcdc_pkg::*;
#(
  parameter int IRQ_W  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_variant,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              pal_valid,
  input  logic              pal_ready,
  output logic              pal_write,
  output logic [6:0]        pal_index,
  output logic [DATA_W-1:0] pal_wdata,
  input  logic [DATA_W-1:0] pal_rdata,
  input  logic [IRQ_W-1:0]  evt_set,
  output logic              irq,
  output logic              disp_on,
  output logic [2:0]        bpp_mode,
  output logic              ctl_bgr,
  output logic              ctl_be_byte,
  output logic              ctl_be_pixel,
  output logic [10:0]       line_pixels,
  output logic [10:0]       line_count,
  output logic              geom_changed
);
  localparam int N_TIM = 4;
  localparam int PIX_W = 11;

  lcdc_sel_t         sel;
  logic [6:0]        pal_idx;
  logic [2:0]        id_idx;
  logic              swap, ext;
  logic              fire, wr, rd;
  logic [N_TIM-1:0]  tim_sel;
  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] ubase_q, lbase_q, ctrl_q, rdata_c, rsp_q;
  logic [IRQ_W-1:0]  raw_s, mask_s;
  logic              rsp_v_q, geom_q;

  assign swap = (cfg_variant != 2'd0);
  assign ext  = cfg_variant[1];

  lcdc_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(7)) u_dec (
    .addr(req_addr), .swap(swap), .sel(sel), .pal_idx(pal_idx), .id_idx(id_idx)
  );

  assign req_ready = sel.pal ? pal_ready : 1'b1;
  assign fire      = req_valid && req_ready;
  assign wr        = fire && req_write;
  assign rd        = fire && !req_write;

  assign pal_valid = req_valid && sel.pal;
  assign pal_write = req_write;
  assign pal_index = pal_idx;
  assign pal_wdata = req_wdata;

  assign tim_sel = {sel.tim3, sel.tim2, sel.tim1, sel.tim0};

  generate
    for (genvar g = 0; g < N_TIM; g++) begin : g_tim
      always_ff @(posedge clk) begin
        if (!rst_n)                tim_q[g] <= '0;
        else if (wr && tim_sel[g]) tim_q[g] <= req_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
      geom_q  <= 1'b0;
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      if (wr && sel.ubase) ubase_q <= req_wdata;
      if (wr && sel.lbase) lbase_q <= req_wdata;
      if (wr && sel.ctrl)  ctrl_q  <= req_wdata;
      geom_q  <= wr && (sel.tim0 || sel.tim1 || sel.ctrl);
      rsp_v_q <= rd;
      if (rd) rsp_q <= rdata_c;
    end
  end

  lcdc_irq_block #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .clr_we(wr && sel.clr), .clr_bits(req_wdata[IRQ_W-1:0]),
    .mask_we(wr && sel.mask), .mask_wdata(req_wdata[IRQ_W-1:0]),
    .raw_o(raw_s), .mask_o(mask_s), .irq_o(irq)
  );

  lcdc_geom #(.DATA_W(DATA_W), .PIX_W(PIX_W), .LINE_W(11)) u_geom (
    .tim0(tim_q[0]), .tim1(tim_q[1]), .line_pixels(line_pixels), .line_count(line_count)
  );

  always_comb begin
    rdata_c = '0;
    if (sel.tim0)                   rdata_c = tim_q[0];
    else if (sel.tim1)              rdata_c = tim_q[1];
    else if (sel.tim2)              rdata_c = tim_q[2];
    else if (sel.tim3)              rdata_c = tim_q[3];
    else if (sel.ubase || sel.ucur) rdata_c = ubase_q;
    else if (sel.lbase || sel.lcur) rdata_c = lbase_q;
    else if (sel.ctrl)              rdata_c = ctrl_q;
    else if (sel.mask)              rdata_c = DATA_W'(mask_s);
    else if (sel.raw)               rdata_c = DATA_W'(raw_s);
    else if (sel.mstat)             rdata_c = DATA_W'(raw_s & mask_s);
    else if (sel.ident)             rdata_c = DATA_W'(lcdc_id_byte(ext, id_idx));
    else if (sel.pal)               rdata_c = pal_rdata;
  end

  assign rsp_valid    = rsp_v_q;
  assign rsp_data     = rsp_q;
  assign geom_changed = geom_q;
  assign disp_on      = ctrl_q[0] & ctrl_q[11];
  assign bpp_mode     = ctrl_q[3:1];
  assign ctl_bgr      = ctrl_q[8];
  assign ctl_be_byte  = ctrl_q[9];
  assign ctl_be_pixel = ctrl_q[10];

  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  a_r11_geom_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel.tim0 || sel.tim1 || sel.ctrl)) |=> geom_changed);

  a_r11_geom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (sel.tim0 || sel.tim1 || sel.ctrl)) |=> !geom_changed);

  a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);

  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);

  a_r4_geom_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(line_pixels) && $stable(line_count)));

  a_r9_pal_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_valid && !pal_ready) |-> !req_ready);
endmodule

// File: tb/lcdc_regfile_bench.sv
module lcdc_regfile_bench;
  localparam int IRQ_W = 5;
  localparam logic [31:0] MMASK = (32'd1 << IRQ_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_variant = 2'd0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid; logic [31:0] rsp_data;
  logic pal_valid, pal_write; logic pal_ready = 1'b1;
  logic [6:0] pal_index; logic [31:0] pal_wdata, pal_rdata;
  logic [IRQ_W-1:0] evt_set = '0;
  logic irq, disp_on, ctl_bgr, ctl_be_byte, ctl_be_pixel, geom_changed;
  logic [2:0] bpp_mode; logic [10:0] line_pixels, line_count;

  int checks = 0, failures = 0;

  // bench model
  logic [31:0] m_tim [4];
  logic [31:0] m_ub, m_lb, m_ctrl, m_mask, m_raw;
  logic [31:0] m_pal [128];
  logic [31:0] pal_mem [128];

  always #5 clk = ~clk;

  lcdc_regfile #(.IRQ_W(IRQ_W)) u_lcdc_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_variant(cfg_variant),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pal_valid(pal_valid), .pal_ready(pal_ready), .pal_write(pal_write),
    .pal_index(pal_index), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
    .evt_set(evt_set), .irq(irq), .disp_on(disp_on), .bpp_mode(bpp_mode),
    .ctl_bgr(ctl_bgr), .ctl_be_byte(ctl_be_byte), .ctl_be_pixel(ctl_be_pixel),
    .line_pixels(line_pixels), .line_count(line_count), .geom_changed(geom_changed)
  );

  // palette store with random stalls
  assign pal_rdata = pal_mem[pal_index];
  logic stall_en = 1'b0;
  always @(posedge clk) begin
    if (pal_valid && pal_ready && pal_write) pal_mem[pal_index] <= pal_wdata;
    pal_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_exp(input logic ext, input int i);
    logic [7:0] base [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (ext && i == 0) return 8'h11;
    if (ext && i == 2) return 8'h24;
    return base[i];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int w = int'(a[11:2]);
    logic sw = (cfg_variant != 2'd0);
    if (a >= 12'hFE0) return {24'h0, id_exp(cfg_variant[1], int'(a[4:2]))};
    if (a[11:9] == 3'b001) return m_pal[a[8:2]];
    case (w)
      0, 1, 2, 3: return m_tim[w];
      4, 11: return m_ub;
      5, 12: return m_lb;
      6: return sw ? m_ctrl : m_mask;
      7: return sw ? m_mask : m_ctrl;
      8: return m_raw;
      9: return m_raw & m_mask;
      default: return 32'h0;
    endcase
  endfunction

  // model update for a write; returns whether geometry pulse is expected
  function automatic logic model_wr(input logic [11:0] a, input logic [31:0] d);
    int w = int'(a[11:2]);
    logic sw = (cfg_variant != 2'd0);
    if (a >= 12'hFE0) return 1'b0;
    if (a[11:9] == 3'b001) begin m_pal[a[8:2]] = d; return 1'b0; end
    case (w)
      0, 1, 2, 3: m_tim[w] = d;
      4: m_ub = d;
      5: m_lb = d;
      6: if (sw) m_ctrl = d; else m_mask = d & MMASK;
      7: if (sw) m_mask = d & MMASK; else m_ctrl = d;
      10: m_raw = m_raw & ~d;
      default: ;
    endcase
    return (w == 0) || (w == 1) || (w == 6 && sw) || (w == 7 && !sw);
  endfunction

  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rdat, output logic gc, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdat = rsp_data; gc = geom_changed; rv = rsp_valid;
  endtask

  task automatic do_wr(input string req, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic gc, rv, egc;
    egc = model_wr(a, d);
    xfer(1'b1, a, d, r, gc, rv);
    chk({req, " R11 geom pulse"}, {31'b0, gc}, {31'b0, egc});
    chk({req, " R12 no rsp on write"}, {31'b0, rv}, 32'd0);
  endtask

  task automatic do_rd(input string req, input logic [11:0] a);
    logic [31:0] r; logic gc, rv;
    xfer(1'b0, a, 32'h0, r, gc, rv);
    chk({req, " R12 rsp_valid"}, {31'b0, rv}, 32'd1);
    chk(req, r, exp_rd(a));
  endtask

  task automatic chk_pins(input string req);
    chk({req, " R4 pixels"}, {21'b0, line_pixels}, ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
    chk({req, " R4 lines"}, {21'b0, line_count}, (m_tim[1] & 32'h3FF) + 32'd1);
    chk({req, " R5 flags"}, {26'b0, disp_on, bpp_mode, ctl_bgr, ctl_be_byte, ctl_be_pixel},
        {26'b0, m_ctrl[0] & m_ctrl[11], m_ctrl[3:1], m_ctrl[8], m_ctrl[9], m_ctrl[10]});
    chk({req, " R7 irq"}, {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    m_ub = '0; m_lb = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
    for (int i = 0; i < 128; i++) begin
      m_pal[i] = 32'hA500_0000 | i; pal_mem[i] = 32'hA500_0000 | i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 line_pixels", {21'b0, line_pixels}, 32'd16);
    chk("R1 line_count", {21'b0, line_count}, 32'd1);
    chk("R1 irq/disp_on", {30'b0, irq, disp_on}, 32'd0);
    for (int w = 0; w < 13; w++) do_rd("R1 reset read", 12'(w * 4));

    // R2 plain registers and current-address mirrors
    do_wr("R2", 12'h008, 32'h1234_5678);
    do_wr("R2", 12'h00C, 32'hCAFE_F00D);
    do_wr("R2", 12'h010, 32'h8000_1000);
    do_wr("R2", 12'h014, 32'h8004_2000);
    do_rd("R2 timing2", 12'h008); do_rd("R2 timing3", 12'h00C);
    do_rd("R2 ucur", 12'h02C); do_rd("R2 lcur", 12'h030);

    // R4 geometry corners
    do_wr("R4", 12'h000, 32'h0000_00FC); chk_pins("R4 max ppl");
    do_wr("R4", 12'h000, 32'hFFFF_FF03); chk_pins("R4 field-only ppl");
    do_wr("R4", 12'h004, 32'h0000_03FF); chk_pins("R4 max lines");
    do_wr("R4", 12'h004, 32'hFFFF_FC00); chk_pins("R4 min lines");

    // R3/R5 base variant: word 7 is control
    do_wr("R5", 12'h01C, 32'h0000_0801); chk_pins("R5 enable+power");
    do_wr("R5", 12'h01C, 32'h0000_0001); chk_pins("R5 enable only");
    do_wr("R5", 12'h01C, 32'h0000_0F0E); chk_pins("R5 flags no enable");
    do_wr("R3", 12'h018, 32'hFFFF_FFFF); do_rd("R3 mask width", 12'h018);
    // R3 swapped variant
    cfg_variant = 2'd1;
    do_rd("R3 swapped ctrl read", 12'h018); do_rd("R3 swapped mask read", 12'h01C);
    do_wr("R3", 12'h018, 32'h0000_0809); chk_pins("R3 ctrl at word6");
    do_wr("R3", 12'h01C, 32'h0000_0006); do_rd("R3 mask at word7", 12'h01C);

    // R8 identification bytes, both sets
    for (int i = 0; i < 8; i++) do_rd("R8 id base", 12'hFE0 + 12'(i * 4));
    cfg_variant = 2'd2;
    for (int i = 0; i < 8; i++) do_rd("R8 id ext", 12'hFE0 + 12'(i * 4));

    // R6/R7 events, clear, set-wins
    @(negedge clk) evt_set = 5'b10011;
    @(negedge clk) evt_set = '0;
    m_raw = 32'h13;
    chk_pins("R7 after events");
    do_rd("R6 raw", 12'h020); do_rd("R6 masked", 12'h024);
    do_wr("R6", 12'h028, 32'h0000_0012); chk_pins("R7 after clear");
    do_rd("R6 raw after clear", 12'h020);
    // set and clear of bit 0 in the same cycle: set wins
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h028; req_wdata = 32'h1F;
    evt_set = 5'b00001;
    @(negedge clk);
    req_valid = 1'b0; evt_set = '0;
    m_raw = 32'h1;
    do_rd("R6 set wins", 12'h020);
    chk_pins("R7 set wins");

    // R10 undefined and read-only writes ignored
    do_wr("R10", 12'h020, 32'hFFFF_FFFF);
    do_wr("R10", 12'h024, 32'hFFFF_FFFF);
    do_wr("R10", 12'h02C, 32'h1111_1111);
    do_wr("R10", 12'h034, 32'h2222_2222);
    do_wr("R10", 12'h100, 32'h3333_3333);
    do_wr("R10", 12'hFE4, 32'h4444_4444);
    do_rd("R10 raw kept", 12'h020); do_rd("R10 ucur kept", 12'h02C);
    do_rd("R10 undef word13", 12'h034); do_rd("R10 undef 0x100", 12'h100);
    do_rd("R10 undef 0x400", 12'h400); do_rd("R10 id kept", 12'hFE4);

    // R9 palette forwarding under stalls
    stall_en = 1'b1;
    do_wr("R9", 12'h200, 32'hDEAD_0000);
    do_wr("R9", 12'h3FC, 32'hDEAD_007F);
    do_rd("R9 first entry", 12'h200); do_rd("R9 last entry", 12'h3FC);
    do_rd("R9 untouched entry", 12'h244);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom % 10;
      if (pick < 6) a = 12'($urandom % 14) << 2;
      else if (pick < 8) a = 12'h200 | (12'($urandom % 128) << 2);
      else if (pick < 9) a = 12'hFE0 | (12'($urandom % 8) << 2);
      else a = 12'($urandom % 4096) & 12'hFFC;
      d = $urandom;
      if (n % 50 == 0) cfg_variant = 2'($urandom % 4);
      if ($urandom % 2) do_wr("R2 random write", a, d);
      else do_rd("R2 random read", a);
      if (n % 20 == 0) chk_pins("R5 random pins");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule